// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block keeps the 8-bit status byte of a serial flash device and rules on every write-type request. A command decoder in front of it raises a one-cycle strobe per decoded command: latch set, latch clear, status write with its data byte, page program or sector erase with a 24-bit address, and whole-array erase. The block weighs the write-enable latch, the block-protect level and the hardware lock together. It answers each strobe with an accept or a reject flag. When it accepts a write-type command it also pulses a start line, with an operation code, to the cycle timer.

While an internal cycle is running, the busy bit in the status byte reads 1. The block ignores every new strobe until the timer returns its done pulse. A status write takes effect on that done pulse, not when it is accepted. The protect bits and the status-write lock bit live in storage that the volatile reset does not clear. They start from a parameter value at power-up.

Top module: `fsr_wp_ctrl`

## Requirements
- R1: The status byte reads {LOCK, 0, 0, PROT[2:0], WEL, BUSY}, with LOCK at bit 7, PROT at bits 4:2, the write-enable latch at bit 1 and the busy flag at bit 0; bits 6:5 always read 0. With default parameters the byte reads 8'h00 after the first reset.
- R2: When idle, a latch-set strobe sets WEL and a latch-clear strobe clears it. Either one raises `cmd_ack` in the following cycle and gives no start pulse.
- R3: When WEL is 0, a status write, page program, sector erase or whole-array erase is rejected: `cmd_nak` is 1 in the following cycle.
- R4: An accepted write-type command gives `cmd_ack`, a one-cycle `cyc_start` and BUSY=1 in the cycle after the strobe. `cyc_op` carries 0 for status write, 1 for page program, 2 for sector erase and 3 for whole-array erase.
- R5: PROT selects a protected region of the 24-bit address space: none for 0, the top 1/2^(7-PROT) for 1 to 6, and everything for 7. A page program or sector erase whose address lies in that region is rejected.
- R6: A whole-array erase is accepted only when PROT is 0.
- R7: When LOCK is 1 and `wp_n` is 0, a status write is rejected, and LOCK and PROT do not change.
- R8: An accepted status write loads data bit 7 into LOCK and data bits 4:2 into PROT, in the cycle after the `cyc_done` pulse that ends its cycle.
- R9: A `cyc_done` pulse while BUSY is 1 clears BUSY and WEL in the next cycle. A `cyc_done` pulse while BUSY is 0 has no effect.
- R10: While BUSY is 1, every command strobe is ignored: it gives neither `cmd_ack` nor `cmd_nak`, and the status byte does not change.
- R11: A rejected command leaves WEL unchanged and gives no start pulse.
- R12: `rst_n` clears WEL, BUSY and any pending status write. LOCK and PROT keep their values across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Latch-set strobe |
| cmd_wrdi | input | 1 | Latch-clear strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte for a status write |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Whole-array erase strobe |
| cmd_addr | input | ADDR_W | Target address for page program and sector erase |
| cyc_done | input | 1 | End-of-cycle pulse from the cycle timer |
| status | output | 8 | Status byte |
| cmd_ack | output | 1 | Command accepted, one cycle after the strobe |
| cmd_nak | output | 1 | Command rejected, one cycle after the strobe |
| cyc_start | output | 1 | Start pulse for the internal cycle |
| cyc_op | output | 2 | Operation code, valid with `cyc_start` |

## Verification
Every result is one register stage behind its cause. The ack, nak, start pulse, operation code and the WEL and BUSY bits all follow the strobe by one clock. The committed protect and lock bits follow the `cyc_done` pulse by one clock. For this reason the bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then compares all outputs on the next falling edge with a bench model that is stepped once per stimulus. Random command streams with biased addresses and a toggling `wp_n` run alongside directed cases: the hardware lock, an address on each side of a region boundary, erase under protection, and a reset during a busy cycle.

// File: rtl/fsr_pkg.sv
// Shared types for the flash status / write-protect controller.
package fsr_pkg;
    localparam int PROT_W = 3;

    typedef enum logic [1:0] {
        OP_WRSR = 2'd0,
        OP_PP   = 2'd1,
        OP_SE   = 2'd2,
        OP_BE   = 2'd3
    } cyc_op_e;

    typedef struct packed {
        logic              lock;
        logic [PROT_W-1:0] prot;
    } nv_bits_t;
endpackage

// File: rtl/fsr_prot_map.sv
// Protected-region check. Level v (1..LEVELS-1) protects the addresses
// whose top (LEVELS-v) bits are all ones; level LEVELS protects all, 0 none.
// Assumes ADDR_W >= LEVELS-1.
module fsr_prot_map #(
    parameter int ADDR_W = 24,
    parameter int PROT_W = 3
) (
    input  logic [PROT_W-1:0] prot,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int LEVELS = (1 << PROT_W) - 1;
    localparam int LOW_HI = ADDR_W - LEVELS;

    logic [LEVELS:0] lvl_hit;
    logic            unused_low;

    assign lvl_hit[0]      = 1'b0;
    assign lvl_hit[LEVELS] = 1'b1;

    // one all-ones detector on the top address bits per partial level
    for (genvar v = 1; v < LEVELS; v++) begin : g_lvl
        localparam int TOPB = LEVELS - v;
        assign lvl_hit[v] = &addr[ADDR_W-1 -: TOPB];
    end

    assign hit        = lvl_hit[prot];
    assign unused_low = ^addr[LOW_HI:0];
endmodule

// File: rtl/fsr_nv_bits.sv
// Holds the lock and protect bits. rst_n does not touch them; their
// power-up value comes from INIT. A commit loads new bits.
module fsr_nv_bits
    import fsr_pkg::*;
#(
    parameter logic [PROT_W:0] INIT = '0
) (
    input  logic     clk,
    input  logic     commit,
    input  nv_bits_t wdata,
    output nv_bits_t nv
);
    nv_bits_t nv_q = nv_bits_t'(INIT);

    // load new lock/protect bits when a status write completes
    always_ff @(posedge clk) begin
        if (commit) begin
            nv_q <= wdata;
        end
    end

    assign nv = nv_q;
endmodule

// File: rtl/fsr_accept.sv
// Combinational accept/reject decision for a decoded command strobe.
// Assumes at most one strobe per cycle. While busy, it raises nothing.
module fsr_accept
    import fsr_pkg::*;
(
    input  logic    wren,
    input  logic    wrdi,
    input  logic    wrsr,
    input  logic    pp,
    input  logic    se,
    input  logic    be,
    input  logic    wel,
    input  logic    busy,
    input  logic    lock,
    input  logic    wp_n,
    input  logic    prot_zero,
    input  logic    prot_hit,
    output logic    ack,
    output logic    nak,
    output logic    start,
    output cyc_op_e op,
    output logic    wel_set,
    output logic    wel_clr,
    output logic    take_wrsr
);
    logic hw_locked;
    assign hw_locked = lock && !wp_n;

    // rule on the single active strobe
    always_comb begin
        ack       = 1'b0;
        nak       = 1'b0;
        start     = 1'b0;
        op        = OP_WRSR;
        wel_set   = 1'b0;
        wel_clr   = 1'b0;
        take_wrsr = 1'b0;
        if (!busy) begin
            if (wren) begin
                ack     = 1'b1;
                wel_set = 1'b1;
            end else if (wrdi) begin
                ack     = 1'b1;
                wel_clr = 1'b1;
            end else if (wrsr) begin
                if (wel && !hw_locked) begin
                    ack       = 1'b1;
                    start     = 1'b1;
                    take_wrsr = 1'b1;
                end else begin
                    nak = 1'b1;
                end
            end else if (pp || se) begin
                if (wel && !prot_hit) begin
                    ack   = 1'b1;
                    start = 1'b1;
                    op    = pp ? OP_PP : OP_SE;
                end else begin
                    nak = 1'b1;
                end
            end else if (be) begin
                if (wel && prot_zero) begin
                    ack   = 1'b1;
                    start = 1'b1;
                    op    = OP_BE;
                end else begin
                    nak = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fsr_wp_ctrl.sv
// Flash status register and write-protect controller. It holds WEL and
// BUSY, rules on decoded command strobes, starts the internal cycle and
// commits a status write when the cycle ends. Strobes are one-hot.
module fsr_wp_ctrl
    import fsr_pkg::*;
#(
    parameter int              ADDR_W  = 24,
    parameter logic [PROT_W:0] NV_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cyc_done,
    output logic [7:0]        status,
    output logic              cmd_ack,
    output logic              cmd_nak,
    output logic              cyc_start,
    output logic [1:0]        cyc_op
);
    logic     wel_q, busy_q, pend_wrsr_q;
    nv_bits_t pend_nv_q, nv;
    logic     ack_q, nak_q, start_q;
    cyc_op_e  op_q;

    logic     prot_hit, commit;
    logic     d_ack, d_nak, d_start, d_wel_set, d_wel_clr, d_take;
    cyc_op_e  d_op;
    logic     unused_data;

    assign unused_data = ^{wrsr_data[6:5], wrsr_data[1:0]};
    assign commit      = busy_q && cyc_done && pend_wrsr_q;

    fsr_prot_map #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) prot_i (
        .prot (nv.prot),
        .addr (cmd_addr),
        .hit  (prot_hit)
    );

    fsr_nv_bits #(.INIT(NV_INIT)) nv_i (
        .clk    (clk),
        .commit (commit),
        .wdata  (pend_nv_q),
        .nv     (nv)
    );

    fsr_accept acc_i (
        .wren      (cmd_wren),
        .wrdi      (cmd_wrdi),
        .wrsr      (cmd_wrsr),
        .pp        (cmd_pp),
        .se        (cmd_se),
        .be        (cmd_be),
        .wel       (wel_q),
        .busy      (busy_q),
        .lock      (nv.lock),
        .wp_n      (wp_n),
        .prot_zero (nv.prot == '0),
        .prot_hit  (prot_hit),
        .ack       (d_ack),
        .nak       (d_nak),
        .start     (d_start),
        .op        (d_op),
        .wel_set   (d_wel_set),
        .wel_clr   (d_wel_clr),
        .take_wrsr (d_take)
    );

    // register the decision flags for the cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            nak_q   <= 1'b0;
            start_q <= 1'b0;
            op_q    <= OP_WRSR;
        end else begin
            ack_q   <= d_ack;
            nak_q   <= d_nak;
            start_q <= d_start;
            if (d_start) begin
                op_q <= d_op;
            end
        end
    end

    // volatile state: latch, busy flag and pending status-write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q       <= 1'b0;
            busy_q      <= 1'b0;
            pend_wrsr_q <= 1'b0;
            pend_nv_q   <= '0;
        end else if (busy_q && cyc_done) begin
            busy_q      <= 1'b0;
            wel_q       <= 1'b0;
            pend_wrsr_q <= 1'b0;
        end else if (d_start) begin
            busy_q      <= 1'b1;
            pend_wrsr_q <= d_take;
            if (d_take) begin
                pend_nv_q <= '{lock: wrsr_data[7], prot: wrsr_data[4:2]};
            end
        end else if (d_wel_set) begin
            wel_q <= 1'b1;
        end else if (d_wel_clr) begin
            wel_q <= 1'b0;
        end
    end

    assign status    = {nv.lock, 2'b00, nv.prot, wel_q, busy_q};
    assign cmd_ack   = ack_q;
    assign cmd_nak   = nak_q;
    assign cyc_start = start_q;
    assign cyc_op    = op_q;
endmodule

// File: rtl/fsr_wp_ctrl_chk.sv
// Property checker for fsr_wp_ctrl; sees only the top-level ports.
module fsr_wp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_se,
    input logic       cmd_be,
    input logic       cyc_done,
    input logic [7:0] status,
    input logic       cmd_ack,
    input logic       cmd_nak,
    input logic       cyc_start,
    input logic [1:0] cyc_op
);
    logic any_cmd;
    assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be;

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be}));

    a_r4_ack_nak_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nak));

    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (status[0] && cmd_ack && $past(status[1])));

    a_r6_erase_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cyc_op == 2'd3) |-> (status[4:2] == 3'd0));

    a_r7_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n && !status[0]) |=> $stable(status[7:2]));

    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && cyc_done) |=> (!status[0] && !status[1]));

    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && any_cmd) |=> !(cmd_ack || cmd_nak));

    a_r11_reject_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_nak |-> (status[1] == $past(status[1]) && !cyc_start));
endmodule

bind fsr_wp_ctrl fsr_wp_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .cmd_wren  (cmd_wren),
    .cmd_wrdi  (cmd_wrdi),
    .cmd_wrsr  (cmd_wrsr),
    .cmd_pp    (cmd_pp),
    .cmd_se    (cmd_se),
    .cmd_be    (cmd_be),
    .cyc_done  (cyc_done),
    .status    (status),
    .cmd_ack   (cmd_ack),
    .cmd_nak   (cmd_nak),
    .cyc_start (cyc_start),
    .cyc_op    (cyc_op)
);

// File: tb/fsr_wp_ctrl_tb_top.sv
// Self-checking bench: directed cases plus seeded random commands
// compared against a bench-side model stepped once per stimulus.
module fsr_wp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
    logic        cmd_pp = 1'b0, cmd_se = 1'b0, cmd_be = 1'b0, cyc_done = 1'b0;
    logic [7:0]  wrsr_data = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  status;
    logic        cmd_ack, cmd_nak, cyc_start;
    logic [1:0]  cyc_op;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // model state
    logic       m_wel = 0, m_busy = 0, m_lock = 0, m_pw = 0;
    logic [2:0] m_prot = 0;
    logic [3:0] m_pd = 0;
    logic       e_ack, e_nak, e_start;
    logic [1:0] e_op;

    always #5 clk = ~clk;

    fsr_wp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .cmd_pp(cmd_pp), .cmd_se(cmd_se),
        .cmd_be(cmd_be), .cmd_addr(cmd_addr), .cyc_done(cyc_done),
        .status(status), .cmd_ack(cmd_ack), .cmd_nak(cmd_nak),
        .cyc_start(cyc_start), .cyc_op(cyc_op)
    );

    function automatic bit in_region(logic [2:0] p, logic [23:0] a);
        longint size, span;
        if (p == 3'd0) return 1'b0;
        if (p == 3'd7) return 1'b1;
        size = 64'd1 << 24;
        span = size >> (7 - p);
        return longint'(a) >= (size - span);
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // op: 0 none, 1 set latch, 2 clear latch, 3 status write, 4 program,
    //     5 sector erase, 6 array erase, 7 done pulse
    task automatic model_step(int op, logic [23:0] a, logic [7:0] d, logic wp, output string tag);
        e_ack = 0; e_nak = 0; e_start = 0; e_op = 0; tag = "R1";
        if (op == 7) begin
            tag = "R9";
            if (m_busy) begin
                if (m_pw) begin
                    tag = "R8";
                    m_lock = m_pd[3];
                    m_prot = m_pd[2:0];
                end
                m_busy = 0; m_wel = 0; m_pw = 0;
            end
        end else if (op != 0 && m_busy) begin
            tag = "R10";
        end else begin
            case (op)
                1: begin e_ack = 1; m_wel = 1; tag = "R2"; end
                2: begin e_ack = 1; m_wel = 0; tag = "R2"; end
                3: begin
                    if (!m_wel) begin e_nak = 1; tag = "R3"; end
                    else if (m_lock && !wp) begin e_nak = 1; tag = "R7"; end
                    else begin
                        e_ack = 1; e_start = 1; e_op = 2'd0; tag = "R4";
                        m_busy = 1; m_pw = 1; m_pd = {d[7], d[4:2]};
                    end
                end
                4, 5: begin
                    if (!m_wel) begin e_nak = 1; tag = "R3"; end
                    else if (in_region(m_prot, a)) begin e_nak = 1; tag = "R5"; end
                    else begin
                        e_ack = 1; e_start = 1; e_op = 2'(op - 3); tag = "R4";
                        m_busy = 1;
                    end
                end
                6: begin
                    if (!m_wel) begin e_nak = 1; tag = "R3"; end
                    else if (m_prot != 3'd0) begin e_nak = 1; tag = "R6"; end
                    else begin
                        e_ack = 1; e_start = 1; e_op = 2'd3; tag = "R4";
                        m_busy = 1;
                    end
                end
                default: ;
            endcase
        end
    endtask

    // drive one stimulus at a falling edge, check one clock later
    task automatic do_cyc(int op, logic [23:0] a, logic [7:0] d, logic wp);
        string tag;
        cmd_wren = (op == 1); cmd_wrdi = (op == 2); cmd_wrsr = (op == 3);
        cmd_pp = (op == 4); cmd_se = (op == 5); cmd_be = (op == 6);
        cyc_done = (op == 7);
        cmd_addr = a; wrsr_data = d; wp_n = wp;
        model_step(op, a, d, wp, tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, "ack", {7'd0, cmd_ack}, {7'd0, e_ack});
        check(tag, "nak", {7'd0, cmd_nak}, {7'd0, e_nak});
        check(tag, "start", {7'd0, cyc_start}, {7'd0, e_start});
        if (e_start) check(tag, "op", {6'd0, cyc_op}, {6'd0, e_op});
        check(tag, "status", status, {m_lock, 2'b00, m_prot, m_wel, m_busy});
        if (e_nak) check("R11", "wel after reject", {7'd0, status[1]}, {7'd0, m_wel});
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0;
        cmd_se = 0; cmd_be = 0; cyc_done = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_wel = 0; m_busy = 0; m_pw = 0;
    endtask

    function automatic int pick_op();
        int r = $urandom_range(0, 99);
        if (r < 22) return 1;
        if (r < 28) return 2;
        if (r < 40) return 3;
        if (r < 55) return 4;
        if (r < 65) return 5;
        if (r < 72) return 6;
        if (r < 90) return 7;
        return 0;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (2) @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", "reset status", status, 8'h00);
        check("R1", "reset ack/nak/start", {5'd0, cmd_ack, cmd_nak, cyc_start}, 8'h00);
        do_cyc(4, 24'h000100, 8'h00, 1);   // R3: program without latch
        do_cyc(1, 24'h0, 8'h00, 1);        // R2: set latch
        do_cyc(3, 24'h0, 8'h9C, 1);        // R4: status write lock=1 prot=7
        do_cyc(4, 24'h000000, 8'h00, 1);   // R10: ignored while busy
        do_cyc(0, 24'h0, 8'h00, 1);
        do_cyc(7, 24'h0, 8'h00, 1);        // R8: commit -> 8'h9C
        check("R8", "committed status", status, 8'h9C);
        do_cyc(1, 24'h0, 8'h00, 0);
        do_cyc(3, 24'h0, 8'h00, 0);        // R7: locked by pin
        check("R7", "locked status", status, 8'h9E);
        do_cyc(3, 24'h0, 8'h08, 1);        // pin high: prot=2 accepted
        do_cyc(7, 24'h0, 8'h00, 1);
        check("R8", "prot=2 status", status, 8'h08);
        do_cyc(1, 24'h0, 8'h00, 1);
        do_cyc(4, 24'hF80000, 8'h00, 1);   // R5: first protected address
        do_cyc(5, 24'hF7FFFF, 8'h00, 1);   // R5: just below the region
        do_cyc(7, 24'h0, 8'h00, 1);
        do_cyc(1, 24'h0, 8'h00, 1);
        do_cyc(6, 24'h0, 8'h00, 1);        // R6: erase rejected, prot != 0
        do_cyc(2, 24'h0, 8'h00, 1);        // R2: clear latch
        do_cyc(7, 24'h0, 8'h00, 1);        // R9: done while idle
        do_cyc(1, 24'h0, 8'h00, 1);
        do_cyc(5, 24'h000000, 8'h00, 1);   // start a cycle, then reset
        do_reset();
        check("R12", "status after reset", status, 8'h08);
        do_cyc(7, 24'h0, 8'h00, 1);
        do_cyc(1, 24'h0, 8'h00, 1);
        do_cyc(3, 24'h0, 8'h00, 1);        // clear prot back to 0
        do_cyc(7, 24'h0, 8'h00, 1);
        do_cyc(1, 24'h0, 8'h00, 1);
        do_cyc(6, 24'h0, 8'h00, 1);        // R6: erase accepted with prot 0
        do_cyc(7, 24'h0, 8'h00, 1);
        for (int i = 0; i < 4000; i++) begin
            int op = pick_op();
            logic [23:0] a = 24'($urandom);
            logic [7:0] d = 8'($urandom);
            logic wp = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 1) == 1) a = a | (24'hFFFFFF << $urandom_range(17, 23));
            if ($urandom_range(0, 2) == 0) d[4:2] = 3'd0;
            do_cyc(op, a, d, wp);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule